// File: doc/BRIEF.md
# Serial loopback enable controller

This block sequences a multi-lane serial link core into and out of its internal transmit-to-receive serial loopback. It owns the core's active-low reset line and a small memory-mapped register master. On an enter request it pulses the core reset, waits a fixed settling time so that register access is legal again, and writes ones into the per-lane loopback bits of the core's loopback control register. It then waits until the receive lanes report alignment.

On an exit request it only pulses the core reset, because reset returns every loopback bit to zero, and then waits for alignment again. Alignment is taken either from a status register read over the bus or from a direct alignment input; a parameter picks the source at build time. A watchdog on the alignment wait sets a sticky error and drops back to idle, so a link that never comes up cannot hold the sequencer forever.

Top module: `serial_lpbk_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it returns high, `busy`, `loopback_active`, `done` and `timeout_err` are 0, `core_rst_n` is 1 and neither `bus_write` nor `bus_read` is asserted.
- R2: In idle, a one-cycle `req_enable` or `req_disable` makes `busy` 1 on the next cycle. When both are high together, the request is treated as an enter. Any request seen while `busy` is 1 is ignored: it starts no second core reset, and the ongoing request completes unchanged.
- R3: After a request is accepted, `core_rst_n` is low for exactly `RST_CYC` consecutive cycles, starting the cycle after acceptance. It goes low exactly once per request.
- R4: No bus command is issued while `core_rst_n` is low. The first bus command begins exactly `SETTLE_CYC`+1 cycles after `core_rst_n` returns high.
- R5: An enter request makes exactly one write, to address `LOOP_ADDR` (default 0x12), with data bits [NUM_LANES-1:0] all ones and every other bit zero. An exit request writes nothing.
- R6: While `bus_waitreq` is high, a pending command stays asserted with stable address and write data. `bus_write` and `bus_read` are never high together. A read completes only on a later `bus_rvalid`.
- R7: With register-sourced alignment (`ALIGN_FROM_PIN`=0), the block reads address `STAT_ADDR` (default 0x20). It treats the lanes as aligned only when bit `ALIGN_BIT` (default 1) of the returned data is 1. Otherwise it issues another read.
- R8: With pin-sourced alignment (`ALIGN_FROM_PIN`=1), the request completes only once `lanes_aligned_in` is 1, and no bus read is ever issued.
- R9: On alignment, `done` is high for exactly one cycle, and `busy` is 0 in that same cycle. After that, `loopback_active` is 1 after an enter request and 0 after an exit request.
- R10: `loopback_active` is 0 from the first busy cycle of any accepted request.
- R11: If alignment is not seen within `ALIGN_TIMEOUT` cycles of the alignment wait, `timeout_err` becomes 1 and stays 1 until `rst_n` is low. In that case `busy` returns to 0, no `done` pulse occurs and `loopback_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_enable | input | 1 | Request to enter serial loopback |
| req_disable | input | 1 | Request to leave serial loopback |
| core_rst_n | output | 1 | Active-low reset to the link core |
| bus_addr | output | ADDR_W | Register address |
| bus_write | output | 1 | Write command |
| bus_read | output | 1 | Read command |
| bus_wdata | output | DATA_W | Write data |
| bus_waitreq | input | 1 | Target stall; the command is held while high |
| bus_rdata | input | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | input | 1 | One-cycle read data strobe |
| lanes_aligned_in | input | 1 | Direct lane alignment indication |
| busy | output | 1 | A request is in progress |
| loopback_active | output | 1 | The core was last placed in loopback successfully |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Sticky alignment timeout flag |

## Verification
Every cycle, the assertions guard the bus protocol: held commands under stall, no read and write together, and no bus traffic during core reset. They also check the content of the loopback write, the status read address, the single-cycle `done` coinciding with idle, the clearing of `loopback_active` at request start, and the stickiness of the error flag. The exact core reset width, the exact settling count, that an exit writes nothing, that a poll result with the alignment bit clear leads to a new read, and that requests arriving mid-sequence leave no trace can only be shown by the bench scenarios. The same holds for the timeout path and for completion driven by the alignment pin.

// File: rtl/lpbk_pkg.sv
// Package: shared state encodings for the loopback sequencer and its bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package lpbk_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RST,
        SEQ_SETTLE,
        SEQ_WRITE,
        SEQ_ALIGN
    } seq_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WR,
        BUS_RD,
        BUS_RWAIT
    } bus_state_t;

    typedef enum logic {
        OP_EXIT,
        OP_ENTER
    } lpbk_op_t;

endpackage

// File: rtl/lpbk_cnt.sv
// Module: saturating up-counter with synchronous clear.
// Assumes: clear has priority over enable; the count holds at all ones.
module lpbk_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count
);

    // Count enabled cycles, restart on clear, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (en && (count != {WIDTH{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lpbk_bus_master.sv
// Module: single-outstanding register master with a stall input.
// Assumes: a command is accepted on a cycle with bus_waitreq low; read data
// returns with a one-cycle bus_rvalid strictly after acceptance; callers
// raise cmd_wr or cmd_rd only while cmd_ready is high.
module lpbk_bus_master
    import lpbk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              wr_done,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_read,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_waitreq,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid
);

    bus_state_t st;

    // Launch one command, hold it through stalls, then await read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= BUS_IDLE;
            bus_write <= 1'b0;
            bus_read  <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (st)
                BUS_IDLE: begin
                    if (cmd_wr) begin
                        bus_write <= 1'b1;
                        bus_addr  <= cmd_addr;
                        bus_wdata <= cmd_wdata;
                        st        <= BUS_WR;
                    end else if (cmd_rd) begin
                        bus_read  <= 1'b1;
                        bus_addr  <= cmd_addr;
                        bus_wdata <= '0;
                        st        <= BUS_RD;
                    end
                end
                BUS_WR: begin
                    if (!bus_waitreq) begin
                        bus_write <= 1'b0;
                        st        <= BUS_IDLE;
                    end
                end
                BUS_RD: begin
                    if (!bus_waitreq) begin
                        bus_read <= 1'b0;
                        st       <= BUS_RWAIT;
                    end
                end
                BUS_RWAIT: begin
                    if (bus_rvalid) begin
                        st <= BUS_IDLE;
                    end
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    // Completion strobes and return data seen by the sequencer.
    always_comb begin
        cmd_ready = (st == BUS_IDLE);
        wr_done   = (st == BUS_WR) && !bus_waitreq;
        rd_done   = (st == BUS_RWAIT) && bus_rvalid;
        rd_data   = bus_rdata;
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_waitreq) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata))); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr))); // R6
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_write && bus_read)); // R6

endmodule

// File: rtl/serial_lpbk_ctrl.sv
// Module: serial loopback enter/exit sequencer (top).
// Does: pulses the link core reset, waits a settling period, writes the
// per-lane loopback bits on entry, then waits for lane alignment taken from a
// status register poll or a direct pin (chosen by ALIGN_FROM_PIN).
// Assumes: the core clears its loopback bits while its reset is low; requests
// are single-cycle pulses; RST_CYC, SETTLE_CYC and ALIGN_TIMEOUT are >= 1.
module serial_lpbk_ctrl
    import lpbk_pkg::*;
#(
    parameter int                NUM_LANES      = 4,
    parameter int                ADDR_W         = 8,
    parameter int                DATA_W         = 32,
    parameter int                RST_CYC        = 4,
    parameter int                SETTLE_CYC     = 1024,
    parameter int                ALIGN_TIMEOUT  = 65536,
    parameter logic [ADDR_W-1:0] LOOP_ADDR      = 'h12,
    parameter logic [ADDR_W-1:0] STAT_ADDR      = 'h20,
    parameter int                ALIGN_BIT      = 1,
    parameter bit                ALIGN_FROM_PIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_enable,
    input  logic              req_disable,
    output logic              core_rst_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_read,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_waitreq,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid,
    input  logic              lanes_aligned_in,
    output logic              busy,
    output logic              loopback_active,
    output logic              done,
    output logic              timeout_err
);

    localparam int PH_MAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TO_W   = $clog2(ALIGN_TIMEOUT + 1);
    localparam logic [PH_W-1:0] RST_LAST    = PH_W'(RST_CYC - 1);
    localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(SETTLE_CYC - 1);
    localparam logic [TO_W-1:0] TO_LAST     = TO_W'(ALIGN_TIMEOUT - 1);
    localparam logic [DATA_W-1:0] LANE_MASK =
        {{(DATA_W - NUM_LANES){1'b0}}, {NUM_LANES{1'b1}}};

    seq_state_t state, state_nxt;
    lpbk_op_t   op;

    logic              accept, finish, expire;
    logic              cmd_wr, cmd_rd, cmd_ready;
    logic              wr_done, rd_done;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] cmd_addr;
    logic [PH_W-1:0]   ph_cnt;
    logic [TO_W-1:0]   to_cnt;
    logic              to_expired;
    logic              align_hit;
    logic              abort_ok;

    // Phase timer: measures the reset pulse and the settling wait.
    lpbk_cnt #(.WIDTH(PH_W)) u_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_nxt != state),
        .en    (1'b1),
        .count (ph_cnt)
    );

    // Alignment watchdog: counts cycles spent waiting for alignment.
    lpbk_cnt #(.WIDTH(TO_W)) u_align_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != SEQ_ALIGN),
        .en    (state == SEQ_ALIGN),
        .count (to_cnt)
    );

    assign to_expired = (to_cnt >= TO_LAST);

    // Alignment source selected at build time.
    generate
        if (ALIGN_FROM_PIN) begin : g_pin_align
            logic unused_rd;
            assign unused_rd = ^{rd_done, rd_data};
            assign align_hit = lanes_aligned_in;
            assign abort_ok  = 1'b1;
            assign cmd_rd    = 1'b0;
        end else begin : g_reg_align
            logic unused_pin;
            assign unused_pin = lanes_aligned_in;
            assign align_hit  = rd_done && rd_data[ALIGN_BIT];
            assign abort_ok   = cmd_ready;
            assign cmd_rd     = (state == SEQ_ALIGN) && cmd_ready && !to_expired;
        end
    endgenerate

    // Next-state decision for the sequencer.
    always_comb begin
        state_nxt = state;
        accept    = 1'b0;
        finish    = 1'b0;
        expire    = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (req_enable || req_disable) begin
                    accept    = 1'b1;
                    state_nxt = SEQ_RST;
                end
            end
            SEQ_RST: begin
                if (ph_cnt == RST_LAST) state_nxt = SEQ_SETTLE;
            end
            SEQ_SETTLE: begin
                if (ph_cnt == SETTLE_LAST)
                    state_nxt = (op == OP_ENTER) ? SEQ_WRITE : SEQ_ALIGN;
            end
            SEQ_WRITE: begin
                if (wr_done) state_nxt = SEQ_ALIGN;
            end
            SEQ_ALIGN: begin
                if (align_hit) begin
                    finish    = 1'b1;
                    state_nxt = SEQ_IDLE;
                end else if (to_expired && abort_ok) begin
                    expire    = 1'b1;
                    state_nxt = SEQ_IDLE;
                end
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // Command selection toward the register master.
    always_comb begin
        cmd_wr   = (state == SEQ_WRITE) && cmd_ready;
        cmd_addr = (state == SEQ_WRITE) ? LOOP_ADDR : STAT_ADDR;
    end

    // Sequencer registers, operation latch and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= SEQ_IDLE;
            op              <= OP_EXIT;
            done            <= 1'b0;
            loopback_active <= 1'b0;
            timeout_err     <= 1'b0;
        end else begin
            state <= state_nxt;
            done  <= finish;
            if (accept) begin
                op              <= req_enable ? OP_ENTER : OP_EXIT;
                loopback_active <= 1'b0;
            end
            if (finish) loopback_active <= (op == OP_ENTER);
            if (expire) timeout_err <= 1'b1;
        end
    end

    // Status and core reset outputs decoded from the state register.
    always_comb begin
        busy       = (state != SEQ_IDLE);
        core_rst_n = (state != SEQ_RST);
    end

    lpbk_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_rd      (cmd_rd),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (LANE_MASK),
        .cmd_ready   (cmd_ready),
        .wr_done     (wr_done),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .bus_addr    (bus_addr),
        .bus_write   (bus_write),
        .bus_read    (bus_read),
        .bus_wdata   (bus_wdata),
        .bus_waitreq (bus_waitreq),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid)
    );

    AST_RST_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> busy); // R3
    AST_QUIET_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> !(bus_write || bus_read)); // R4
    AST_WR_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write |-> (bus_addr == LOOP_ADDR && bus_wdata == LANE_MASK)); // R5
    AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_read |-> (bus_addr == STAT_ADDR)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_ACTIVE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !loopback_active); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err); // R11

endmodule

// File: tb/test_serial_lpbk_ctrl.sv
// Bench register target: stalls at random, holds the loopback register
// (cleared while the core reset is low), answers status reads after 1..3
// cycles with the alignment flag in bit 1 and its inverse in bit 0.
module test_bus_slave #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          core_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          read,
    input  logic [DW-1:0] wdata,
    output logic          waitreq,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    input  logic          status_align,
    input  logic          stall_en,
    output int            wr_cnt,
    output int            rd_cnt,
    output int            bad_rd_addr,
    output int            hit_cnt,
    output int            hold_bad,
    output logic [DW-1:0] loop_reg,
    output logic [DW-1:0] last_wdata,
    output logic [AW-1:0] last_waddr
);
    int            rv_left = 0;
    logic          p_pend = 1'b0, p_w = 1'b0, p_r = 1'b0;
    logic [AW-1:0] p_a = '0;
    logic [DW-1:0] p_d = '0;

    initial begin
        waitreq = 1'b0; rdata = '0; rvalid = 1'b0;
        wr_cnt = 0; rd_cnt = 0; bad_rd_addr = 0; hit_cnt = 0; hold_bad = 0;
        loop_reg = '0; last_wdata = '0; last_waddr = '0;
    end

    always @(posedge clk) begin
        if (p_pend && (write != p_w || read != p_r || addr != p_a || (p_w && wdata != p_d)))
            hold_bad <= hold_bad + 1;
        p_pend <= (write || read) && waitreq;
        p_w <= write; p_r <= read; p_a <= addr; p_d <= wdata;
        waitreq <= stall_en ? ($urandom_range(0, 2) == 0) : 1'b0;
        rvalid  <= 1'b0;
        if (rv_left != 0) begin
            rv_left <= rv_left - 1;
            if (rv_left == 1) begin
                rvalid <= 1'b1;
                rdata  <= {{(DW-2){1'b0}}, status_align, ~status_align};
                if (status_align) hit_cnt <= hit_cnt + 1;
            end
        end
        if (write && !waitreq) begin
            wr_cnt <= wr_cnt + 1;
            last_wdata <= wdata;
            last_waddr <= addr;
            if (addr == AW'('h12)) loop_reg <= wdata & {{(DW-NL){1'b0}}, {NL{1'b1}}};
        end
        if (read && !waitreq) begin
            rd_cnt  <= rd_cnt + 1;
            rv_left <= $urandom_range(1, 3);
            if (addr != AW'('h20)) bad_rd_addr <= bad_rd_addr + 1;
        end
        if (!core_rst_n) loop_reg <= '0;
    end
endmodule

module test_serial_lpbk_ctrl;
    localparam int NL = 4, AW = 8, DW = 32, RC = 3, SC = 32, TO = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;

    // ---- register-polled instance ----
    logic a_en = 0, a_dis = 0, a_core_rst_n, a_write, a_read, a_waitreq, a_rvalid;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic a_busy, a_active, a_done, a_err, a_status = 0, a_stall = 0;
    int a_wr, a_rd, a_bad_rd, a_hit, a_hold_bad;
    logic [DW-1:0] a_loop, a_lwd;
    logic [AW-1:0] a_lwa;

    serial_lpbk_ctrl #(.NUM_LANES(NL), .ADDR_W(AW), .DATA_W(DW), .RST_CYC(RC),
        .SETTLE_CYC(SC), .ALIGN_TIMEOUT(TO), .ALIGN_FROM_PIN(1'b0)) i_serial_lpbk_ctrl (
        .clk(clk), .rst_n(rst_n), .req_enable(a_en), .req_disable(a_dis),
        .core_rst_n(a_core_rst_n), .bus_addr(a_addr), .bus_write(a_write),
        .bus_read(a_read), .bus_wdata(a_wdata), .bus_waitreq(a_waitreq),
        .bus_rdata(a_rdata), .bus_rvalid(a_rvalid), .lanes_aligned_in(1'b0),
        .busy(a_busy), .loopback_active(a_active), .done(a_done), .timeout_err(a_err));

    test_bus_slave #(.AW(AW), .DW(DW), .NL(NL)) i_slave_a (
        .clk(clk), .core_rst_n(a_core_rst_n), .addr(a_addr), .write(a_write),
        .read(a_read), .wdata(a_wdata), .waitreq(a_waitreq), .rdata(a_rdata),
        .rvalid(a_rvalid), .status_align(a_status), .stall_en(a_stall),
        .wr_cnt(a_wr), .rd_cnt(a_rd), .bad_rd_addr(a_bad_rd), .hit_cnt(a_hit),
        .hold_bad(a_hold_bad), .loop_reg(a_loop), .last_wdata(a_lwd), .last_waddr(a_lwa));

    // ---- pin-aligned instance ----
    logic b_en = 0, b_core_rst_n, b_write, b_read, b_waitreq, b_rvalid, b_pin = 0;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;
    logic b_busy, b_active, b_done, b_err;
    int b_wr, b_rd, b_bad_rd, b_hit, b_hold_bad, b_done_cnt = 0;
    logic [DW-1:0] b_loop, b_lwd;
    logic [AW-1:0] b_lwa;

    serial_lpbk_ctrl #(.NUM_LANES(NL), .ADDR_W(AW), .DATA_W(DW), .RST_CYC(RC),
        .SETTLE_CYC(SC), .ALIGN_TIMEOUT(TO), .ALIGN_FROM_PIN(1'b1)) i_serial_lpbk_ctrl_pin (
        .clk(clk), .rst_n(rst_n), .req_enable(b_en), .req_disable(1'b0),
        .core_rst_n(b_core_rst_n), .bus_addr(b_addr), .bus_write(b_write),
        .bus_read(b_read), .bus_wdata(b_wdata), .bus_waitreq(b_waitreq),
        .bus_rdata(b_rdata), .bus_rvalid(b_rvalid), .lanes_aligned_in(b_pin),
        .busy(b_busy), .loopback_active(b_active), .done(b_done), .timeout_err(b_err));

    test_bus_slave #(.AW(AW), .DW(DW), .NL(NL)) i_slave_b (
        .clk(clk), .core_rst_n(b_core_rst_n), .addr(b_addr), .write(b_write),
        .read(b_read), .wdata(b_wdata), .waitreq(b_waitreq), .rdata(b_rdata),
        .rvalid(b_rvalid), .status_align(1'b0), .stall_en(1'b1),
        .wr_cnt(b_wr), .rd_cnt(b_rd), .bad_rd_addr(b_bad_rd), .hit_cnt(b_hit),
        .hold_bad(b_hold_bad), .loop_reg(b_loop), .last_wdata(b_lwd), .last_waddr(b_lwa));

    // ---- monitor on instance A, sampled away from the active edge ----
    int rst_run = 0, rst_len = 0, rst_pulses = 0, settle_run = 0, settle_len = 0;
    int done_cnt = 0, hit_at_done = 0;
    bit settle_meas = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!a_core_rst_n) rst_run++;
            else if (rst_run != 0) begin
                rst_len = rst_run; rst_pulses++; rst_run = 0;
                settle_run = 0; settle_meas = 1;
            end
            if (a_core_rst_n && settle_meas) begin
                if (a_write || a_read) begin settle_len = settle_run; settle_meas = 0; end
                else settle_run++;
            end
            if (a_done) begin done_cnt++; hit_at_done = a_hit; end
            if (b_done) b_done_cnt++;
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_loop(input bit enter);
        return enter ? longint'((1 << NL) - 1) : 0;
    endfunction

    task automatic wait_idle_a();
        int n = 0;
        while (a_busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    // One request on instance A; dly < 0 keeps alignment low forever.
    task automatic run_a(input bit en, input bit dis, input int dly, input bit stall, input bit mid);
        a_status = 0; a_stall = stall;
        @(negedge clk); a_en = en; a_dis = dis;
        @(negedge clk); a_en = 0; a_dis = 0;
        chk("R2 busy after request", a_busy, 1);
        chk("R10 active cleared on start", a_active, 0);
        while (!a_core_rst_n) @(negedge clk);
        if (mid) begin
            @(negedge clk); a_en = !en; a_dis = 1;
            @(negedge clk); a_en = 0; a_dis = 0;
        end
        if (dly >= 0) begin
            repeat (dly) @(negedge clk);
            a_status = 1;
        end
        wait_idle_a();
        @(negedge clk);
    endtask

    int w0, r0, d0, p0;
    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 busy in reset", a_busy, 0);
        chk("R1 core_rst_n in reset", a_core_rst_n, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle outputs", {a_busy, a_active, a_done, a_err, a_write, a_read}, 0);

        // Directed enter, late alignment so the first polls miss (R3 R4 R5 R7 R9)
        w0 = a_wr; r0 = a_rd; d0 = done_cnt; p0 = rst_pulses;
        run_a(1, 0, 80, 0, 0);
        chk("R3 core reset width", rst_len, RC);
        chk("R3 one reset pulse", rst_pulses - p0, 1);
        chk("R4 settle before first access", settle_len, SC + 1);
        chk("R5 one loopback write", a_wr - w0, 1);
        chk("R5 write address", a_lwa, 'h12);
        chk("R5 write data", a_lwd, exp_loop(1));
        chk("R7 re-polled while not aligned", (a_rd - r0) >= 2, 1);
        chk("R7 status read address", a_bad_rd, 0);
        chk("R7 done only after aligned read", hit_at_done >= 1, 1);
        chk("R9 one done pulse", done_cnt - d0, 1);
        chk("R9 active after enter", a_active, 1);

        // Exit: no write, bits cleared by core reset (R5 R9)
        w0 = a_wr; d0 = done_cnt;
        run_a(0, 1, 10, 1, 0);
        chk("R5 exit writes nothing", a_wr - w0, 0);
        chk("R5 loopback bits cleared", a_loop, 0);
        chk("R9 active after exit", a_active, 0);
        chk("R9 done on exit", done_cnt - d0, 1);

        // Request during busy ignored (R2)
        p0 = rst_pulses;
        run_a(1, 0, 20, 1, 1);
        chk("R2 mid-busy request ignored (pulses)", rst_pulses - p0, 1);
        chk("R2 mid-busy request ignored (active)", a_active, 1);

        // Both requests together: enter wins (R2)
        run_a(0, 1, 5, 0, 0);
        run_a(1, 1, 5, 0, 0);
        chk("R2 simultaneous requests enter", a_active, 1);
        chk("R6 commands held under stall", a_hold_bad, 0);

        // Random mix (R3 R4 R5 R6 R9)
        for (int i = 0; i < 8; i++) begin
            bit op;
            int dly;
            bit st;
            op = 1'($urandom_range(0, 1)); dly = $urandom_range(0, 90); st = 1'($urandom_range(0, 1));
            w0 = a_wr; d0 = done_cnt;
            run_a(op, !op, dly, st, 0);
            chk("R9 random active", a_active, longint'(op));
            chk("R9 random done", done_cnt - d0, 1);
            chk("R5 random write count", a_wr - w0, op ? 1 : 0);
            chk("R5 random loop bits", a_loop, exp_loop(op));
            chk("R3 random reset width", rst_len, RC);
            chk("R4 random settle", settle_len, SC + 1);
        end
        chk("R6 random stall hold", a_hold_bad, 0);

        // Timeout (R11), then stickiness across a good request
        d0 = done_cnt;
        run_a(1, 0, -1, 1, 0);
        chk("R11 error set", a_err, 1);
        chk("R11 busy released", a_busy, 0);
        chk("R11 no done", done_cnt - d0, 0);
        chk("R11 active stays 0", a_active, 0);
        run_a(1, 0, 3, 0, 0);
        chk("R11 error sticky", a_err, 1);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset clears error", a_err, 0);
        chk("R1 reset clears active", a_active, 0);

        // Pin-aligned instance (R8)
        b_pin = 0;
        @(negedge clk); b_en = 1;
        @(negedge clk); b_en = 0;
        repeat (150) @(negedge clk);
        chk("R8 waits for pin", b_busy, 1);
        b_pin = 1;
        repeat (5) @(negedge clk);
        chk("R8 completes on pin", b_busy, 0);
        chk("R8 done pulse", b_done_cnt, 1);
        chk("R8 no reads", b_rd, 0);
        chk("R8 active", b_active, 1);
        chk("R5 pin instance loop bits", b_loop, exp_loop(1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule